// File: doc/BRIEF.md
# Frame Buffer Pixel Fetch Shifter

This block turns a one-bit-per-pixel frame buffer into a serial video stream. It keeps a byte address counter that starts each frame at the first frame-buffer address and walks forward one byte per fetch. Every fetch is a request and grant exchange on a shared memory bus. A one-byte prefetch buffer holds the next byte while the current byte shifts out, so the byte after bit 7 loads on the very next pixel.

Pixel timing comes from outside. A pixel-enable strobe marks pixel slots, a visible flag gates them, and a start-of-frame pulse rewinds the scan. Each visible pixel slot shifts one bit to the pixel output, least significant bit first. The output reads zero whenever the visible flag is low. The frame window is the byte range 0x2400 to 0x3FFF, which is 7168 bytes. The counter stops on the last byte of that range and makes no further requests until the next frame starts.

Top module: `fbPixelFetchShifter`

## Requirements
- R1: After reset, memAddr is 0x2400, pixOut is 0, the prefetch buffer is empty and memReq is 1.
- R2: memReq is 1 exactly when the prefetch buffer is empty and the window is not used up. Once raised, it stays high until a cycle with memGrant high.
- R3: On a cycle where memGrant and memReq are both high, memData is stored in the prefetch buffer and memAddr advances by one. On the following cycle memReq is 0.
- R4: The n-th fetch after a frame start (counting from 0) reads address 0x2400+n. The address changes only on a grant.
- R5: memAddr never leaves 0x2400..0x3FFF. After the byte at 0x3FFF is fetched, memReq stays 0 and memAddr stays 0x3FFF until the next frameStart.
- R6: A pixel step happens only on a clock edge where pixEn and visible are both 1. On other cycles the bit position and the shown bit are kept.
- R7: Each byte supplies 8 consecutive pixel steps, least significant bit first. When the fetches keep up, bit k of the byte at 0x2400+n appears on step 8n+k of the frame.
- R8: The step that follows bit 7 of a byte shows bit 0 of the prefetched byte, with no idle pixel between them.
- R9: pixOut is 0 whenever visible is 0. While visible is 1, pixOut shows the bit of the most recent step, or 0 if no step has happened since the frame started.
- R10: If the prefetch buffer is empty at a byte boundary, that byte slot shows 8 zero pixels. No address is skipped: the byte fetched later fills the next slot.
- R11: frameStart takes priority over a grant or a pixel step in the same cycle. It rewinds the address to 0x2400, empties the buffer and the bit position, and clears the shown bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixEn | input | 1 | Pixel slot strobe |
| visible | input | 1 | High inside the visible area |
| frameStart | input | 1 | Rewinds the scan to the first frame-buffer byte |
| memGrant | input | 1 | Grant for the pending fetch; memData is valid in this cycle |
| memData | input | 8 | Byte returned by video memory |
| memReq | output | 1 | Fetch request, held until granted |
| memAddr | output | 16 | Byte address of the pending or next fetch |
| pixOut | output | 1 | Serial pixel output |

## Verification
The stimulus mixes four patterns. A dense pattern has pixEn and visible high on every cycle, which shows whether bytes run back to back with no gap. A sparse random pattern toggles pixEn and visible, which shows whether the bit position is kept across blanked or idle slots and whether the output is forced to zero. One run withholds grants across a byte boundary, which separates a correct blank slot from a skipped or repeated address. One run scans the whole 7168-byte window, which shows that the counter stops at 0x3FFF and the request falls. A frame start that lands together with a grant and a pixel step checks the priority rule.

// File: rtl/fbShiftPkg.sv
package fbShiftPkg;

  // Strobes from the fetch control to the pixel datapath
  typedef struct packed {
    logic restart;    // rewind scan for a new frame
    logic step;       // one visible pixel slot
    logic loadByte;   // step at a byte boundary: take the prefetched byte
    logic loadBlank;  // byte boundary with nothing prefetched
    logic capture;    // grant accepted: store memData, advance address
  } ctrlStrobes_t;

endpackage

// File: rtl/fbFetchCtrl.sv
module fbFetchCtrl
  import fbShiftPkg::*;
#(
  parameter int unsigned PIX_PER_BYTE = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pixEn,
  input  logic         visible,
  input  logic         frameStart,
  input  logic         memGrant,
  input  logic         atLast,
  output ctrlStrobes_t strobes,
  output logic         memReq
);

  localparam int unsigned CNT_W = (PIX_PER_BYTE > 1) ? $clog2(PIX_PER_BYTE) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PIX_PER_BYTE - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             holdValid;
  logic             windowDone;

  always_comb begin
    strobes.restart   = frameStart;
    strobes.step      = pixEn & visible & ~frameStart;
    strobes.loadByte  = strobes.step & (bitCnt == '0);
    strobes.loadBlank = strobes.loadByte & ~holdValid;
    memReq            = ~holdValid & ~windowDone;
    strobes.capture   = memGrant & memReq & ~frameStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      holdValid  <= 1'b0;
      windowDone <= 1'b0;
    end else if (strobes.restart) begin
      bitCnt     <= '0;
      holdValid  <= 1'b0;
      windowDone <= 1'b0;
    end else begin
      if (strobes.step) begin
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end
      if (strobes.capture) begin
        holdValid <= 1'b1;
      end else if (strobes.loadByte) begin
        holdValid <= 1'b0;
      end
      if (strobes.capture && atLast) begin
        windowDone <= 1'b1;
      end
    end
  end

  // R2
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGrant && !frameStart |=> memReq);

  // R3
  req_drop_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !memReq);

  // R11
  restart_requests_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> memReq);

  // R5
  window_stays_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    windowDone && !frameStart |=> !memReq);

endmodule

// File: rtl/fbPixelPath.sv
module fbPixelPath
  import fbShiftPkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BASE      = 32'h2400,
  parameter int unsigned LIMIT     = 32'h4000,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              visible,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              atLast,
  output logic              pixOut
);

  localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(LIMIT - 1);

  logic [ADDR_W-1:0] addrCnt;
  logic [DATA_W-1:0] holdBuf;
  logic [DATA_W-1:0] shiftReg;
  logic              pixBit;

  logic              holdHead;
  logic              shiftHead;
  logic [DATA_W-1:0] holdRest;
  logic [DATA_W-1:0] shiftRest;

  generate
    if (LSB_FIRST) begin : g_lsbFirst
      assign holdHead  = holdBuf[0];
      assign shiftHead = shiftReg[0];
      assign holdRest  = holdBuf >> 1;
      assign shiftRest = shiftReg >> 1;
    end else begin : g_msbFirst
      assign holdHead  = holdBuf[DATA_W-1];
      assign shiftHead = shiftReg[DATA_W-1];
      assign holdRest  = holdBuf << 1;
      assign shiftRest = shiftReg << 1;
    end
  endgenerate

  assign atLast  = (addrCnt == LAST_ADDR);
  assign memAddr = addrCnt;
  assign pixOut  = pixBit & visible;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt  <= FIRST_ADDR;
      holdBuf  <= '0;
      shiftReg <= '0;
      pixBit   <= 1'b0;
    end else if (strobes.restart) begin
      addrCnt  <= FIRST_ADDR;
      shiftReg <= '0;
      pixBit   <= 1'b0;
    end else begin
      if (strobes.capture) begin
        holdBuf <= memData;
        if (!atLast) begin
          addrCnt <= addrCnt + 1'b1;
        end
      end
      if (strobes.loadBlank) begin
        shiftReg <= '0;
        pixBit   <= 1'b0;
      end else if (strobes.loadByte) begin
        shiftReg <= holdRest;
        pixBit   <= holdHead;
      end else if (strobes.step) begin
        shiftReg <= shiftRest;
        pixBit   <= shiftHead;
      end
    end
  end

  // R5
  addr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrCnt >= FIRST_ADDR && addrCnt <= LAST_ADDR);

  // R4
  addr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && !atLast && !strobes.restart |=> addrCnt == $past(addrCnt) + 1'b1);

  // R4
  addr_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture && !strobes.restart |=> $stable(addrCnt));

  // R6
  pixel_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.step && !strobes.restart |=> $stable(pixBit));

  // R11
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> addrCnt == FIRST_ADDR && !pixBit);

endmodule

// File: rtl/fbPixelFetchShifter.sv
module fbPixelFetchShifter
  import fbShiftPkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BASE      = 32'h2400,
  parameter int unsigned LIMIT     = 32'h4000,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              visible,
  input  logic              frameStart,
  input  logic              memGrant,
  input  logic [DATA_W-1:0] memData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pixOut
);

  ctrlStrobes_t strobes;
  logic         atLast;

  fbFetchCtrl #(
    .PIX_PER_BYTE(DATA_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pixEn     (pixEn),
    .visible   (visible),
    .frameStart(frameStart),
    .memGrant  (memGrant),
    .atLast    (atLast),
    .strobes   (strobes),
    .memReq    (memReq)
  );

  fbPixelPath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE     (BASE),
    .LIMIT    (LIMIT),
    .LSB_FIRST(LSB_FIRST)
  ) path_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .visible(visible),
    .memData(memData),
    .memAddr(memAddr),
    .atLast (atLast),
    .pixOut (pixOut)
  );

endmodule

// File: tb/fbPixelFetchShifter_tb_top.sv
`timescale 1ns/1ps
module fbPixelFetchShifter_tb_top;

  localparam int unsigned BASE   = 32'h2400;
  localparam int unsigned WINDOW = 7168;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixEn = 1'b0;
  logic        visible = 1'b0;
  logic        frameStart = 1'b0;
  logic        memGrant = 1'b0;
  logic [7:0]  memData;
  logic        memReq;
  logic [15:0] memAddr;
  logic        pixOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  int         fetchCount;
  bit         holdV;
  logic [7:0] hold;
  logic [7:0] curByte;
  int         bitIdx;
  logic       lastBit;
  int         waitCnt;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] fbyte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h5A;
  endfunction

  assign memData = fbyte(memAddr);

  fbPixelFetchShifter dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .pixEn     (pixEn),
    .visible   (visible),
    .frameStart(frameStart),
    .memGrant  (memGrant),
    .memData   (memData),
    .memReq    (memReq),
    .memAddr   (memAddr),
    .pixOut    (pixOut)
  );

  function automatic bit expReq();
    return !holdV && (fetchCount < WINDOW);
  endfunction

  function automatic logic [15:0] expAddr();
    return 16'(BASE + ((fetchCount < WINDOW) ? fetchCount : WINDOW - 1));
  endfunction

  task automatic modelRestart();
    fetchCount = 0; holdV = 0; hold = '0; curByte = '0;
    bitIdx = 0; lastBit = 1'b0; waitCnt = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(memReq == expReq(), "R2/R5 memReq", int'(memReq), int'(expReq()));
    chk(memAddr == expAddr(), "R4/R5 memAddr", int'(memAddr), int'(expAddr()));
    chk(pixOut == (visible & lastBit), "R7/R9/R10 pixOut", int'(pixOut), int'(visible & lastBit));
  endtask

  // One clock: drive at negedge, update model and compare after posedge
  task automatic cycle(input logic pe, input logic vis, input logic fs, input bit gntEn);
    bit reqBefore;
    bit g;
    @(negedge clk);
    reqBefore = expReq();
    g = gntEn && (($urandom % 4) != 0 || waitCnt >= 2);
    pixEn = pe; visible = vis; frameStart = fs; memGrant = g;
    @(posedge clk);
    #1;
    if (fs) begin
      modelRestart();
    end else begin
      if (pe && vis) begin
        if (bitIdx == 0) begin
          curByte = holdV ? hold : 8'h00;
          holdV = 0;
        end
        lastBit = curByte[bitIdx];
        bitIdx = (bitIdx + 1) % 8;
      end
      if (g && reqBefore) begin
        hold = fbyte(16'(BASE + fetchCount));
        holdV = 1;
        fetchCount++;
        waitCnt = 0;
      end else if (reqBefore) begin
        waitCnt++;
      end
    end
    compareAll();
  endtask

  task automatic startFrame();
    cycle(1'b0, 1'b0, 1'b1, 1'b1);
    repeat (4) cycle(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd7919));
    modelRestart();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R1 reset state
    chk(memAddr == 16'h2400, "R1 reset addr", int'(memAddr), 32'h2400);
    chk(memReq == 1'b1, "R1 reset req", int'(memReq), 1);
    chk(pixOut == 1'b0, "R1 reset pix", int'(pixOut), 0);

    // R7 R8: dense directed run, back-to-back bytes
    startFrame();
    repeat (64) cycle(1'b1, 1'b1, 1'b0, 1'b1);

    // R6 R9: sparse random frames
    for (int f = 0; f < 20; f++) begin
      startFrame();
      for (int c = 0; c < 400; c++) begin
        cycle(logic'(($urandom % 2) == 0), logic'(($urandom % 5) != 0), 1'b0, 1'b1);
      end
    end

    // R10: withhold grants across a byte boundary
    startFrame();
    repeat (4) cycle(1'b1, 1'b1, 1'b0, 1'b1);
    repeat (20) cycle(1'b1, 1'b1, 1'b0, 1'b0);
    repeat (40) cycle(1'b1, 1'b1, 1'b0, 1'b1);

    // R11: frame start together with grant and pixel step
    repeat (3) cycle(1'b1, 1'b1, 1'b0, 1'b1);
    cycle(1'b1, 1'b1, 1'b1, 1'b1);
    chk(memAddr == 16'h2400, "R11 rewind addr", int'(memAddr), 32'h2400);
    chk(pixOut == 1'b0, "R11 pixel cleared", int'(pixOut), 0);
    repeat (4) cycle(1'b0, 1'b0, 1'b0, 1'b1);
    repeat (24) cycle(1'b1, 1'b1, 1'b0, 1'b1);

    // R5: full window scan, counter stops at last byte
    startFrame();
    repeat (WINDOW * 8 + 40) cycle(1'b1, 1'b1, 1'b0, 1'b1);
    chk(memReq == 1'b0, "R5 window exhausted req", int'(memReq), 0);
    chk(memAddr == 16'h3FFF, "R5 last addr", int'(memAddr), 32'h3FFF);
    repeat (10) cycle(1'b0, 1'b1, 1'b0, 1'b1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule